// File: doc/BRIEF.md
# Coherent Attribute Table Access Responder

This block answers table-access requests that arrive through a data-object mailbox. A host hands over a request object with its length in dwords and an entry handle. If the request is long enough and names an existing entry, the block queues a response. The host then pops that response one dword at a time through a read port while a ready flag is high.

Each response starts with three header dwords. The first carries the vendor ID and the object type. The second carries the total response length in dwords. The third carries the response code, the table type and the handle of the next entry. The raw bytes of the requested table entry follow the header. The table is a fixed set of six structures that describe one persistent memory region: a region descriptor, four performance entries, and a memory-type entry. The host walks the whole table by feeding each next-handle value back as its following request, and stops when it sees the end marker.

Top module: `cdat_responder`

## Requirements
- R1: After reset `ready_o` is 0.
- R2: A request with `req_len_i` below 3 dwords is dropped. It starts no response and leaves any pending response, and its read position, unchanged.
- R3: Response dword 0 is `{8'h00, OBJ_TYPE, VENDOR_ID}`, with the vendor ID in bits 15:0, the object type in bits 23:16 and zero in bits 31:24 (defaults 16'h1E98 and 8'h02).
- R4: Response dword 1 holds the response length in dwords, 3 + ceil(entry_bytes / 4), in its low bits. That gives 9 for 24-byte entries and 8 for 18-byte entries.
- R5: Response dword 2 is `{next_handle[15:0], table_type 8'h00, rsp_code 8'h00}`. The next handle is the requested handle plus one, or 16'hFFFF for handle 5.
- R6: The entry bytes follow directly from dword 3. Byte k sits in dword 3 + k/4 at bits 8*(k%4) +: 8, and the pad bytes of the last dword are zero.
- R7: Handles 0 to 5 select, in this order: the region descriptor (type 0, 24 bytes), read latency, write latency, read bandwidth, write bandwidth (each type 1, 18 bytes), and the memory-type entry (type 2, 24 bytes). Every entry starts with a sub-header: byte 0 is the type, bytes 3:2 are the byte length. The region and memory-type entries carry a 64-bit length equal to REGION_SIZE at bytes 23:16. The region entry has flag 8'h04 at byte 5. The memory-type entry has attribute 8'h02 at byte 5.
- R8: A performance entry has its kind at byte 6, a 64-bit base unit at bytes 15:8 and a 16-bit value at bytes 17:16. The four entries hold: read latency kind 1, unit 10000, value 15; write latency kind 2, unit 10000, value 25; read bandwidth kind 4, unit 1000, value 16; write bandwidth kind 5, unit 1000, value 16.
- R9: `ready_o` stays 1 while response dwords remain. Each `rd_en_i` pulse while ready moves `rd_data_o` to the next dword. `ready_o` drops after the last dword is popped. A pop while not ready has no effect.
- R10: An accepted request made while a response is pending replaces it. The read position restarts at dword 0 of the new response.
- R11: A request for a handle of 6 or more is dropped. It leaves any pending response unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request object present this cycle |
| req_len_i | input | LEN_W | Request object length in dwords |
| req_handle_i | input | 16 | Requested entry handle |
| rd_en_i | input | 1 | Pop the current response dword |
| ready_o | output | 1 | Response dwords remain |
| rd_data_o | output | 32 | Current response dword |

## Verification
The bench walks all six handles and compares every dword. This covers both entry sizes, so the length rounding, the zero padding and the end-marker chaining are all checked against each other. Short requests and out-of-range handles are tried twice: once with nothing pending and once partway through a response. Both cases tell a true discard apart from a silent reload. A request in the middle of a response shows whether the read position restarts. Pops while idle, followed by a fresh request, show whether stray pops shift the stream.

// File: rtl/cdat_resp_pkg.sv
package cdat_resp_pkg;
  localparam int unsigned NUM_ENTRIES = 6;
  localparam int unsigned HDR_DW      = 3;
  localparam int unsigned REQ_DW      = 3;
  localparam int unsigned ENT_IDX_W   = 3;
  localparam int unsigned DW_IDX_W    = 4;
  localparam int unsigned HANDLE_W    = 16;

  typedef enum logic [7:0] {
    SUB_REGION  = 8'h00,
    SUB_PERF    = 8'h01,
    SUB_MEMTYPE = 8'h02
  } sub_type_e;

  typedef enum logic [7:0] {
    PERF_NONE   = 8'h00,
    PERF_RD_LAT = 8'h01,
    PERF_WR_LAT = 8'h02,
    PERF_RD_BW  = 8'h04,
    PERF_WR_BW  = 8'h05
  } perf_kind_e;

  typedef struct packed {
    perf_kind_e  kind;
    logic [63:0] unit;
    logic [15:0] value;
  } perf_t;

  localparam logic [7:0] REGION_BYTES  = 8'd24;
  localparam logic [7:0] PERF_BYTES    = 8'd18;
  localparam logic [7:0] MEMTYPE_BYTES = 8'd24;
  localparam logic [7:0] NV_FLAG       = 8'h04;
  localparam logic [7:0] MEM_ATTR      = 8'h02;

  function automatic sub_type_e entry_kind(input logic [ENT_IDX_W-1:0] e);
    if (e == 3'd0)      return SUB_REGION;
    else if (e == 3'd5) return SUB_MEMTYPE;
    else                return SUB_PERF;
  endfunction

  function automatic logic [7:0] entry_bytes(input logic [ENT_IDX_W-1:0] e);
    case (entry_kind(e))
      SUB_REGION:  return REGION_BYTES;
      SUB_MEMTYPE: return MEMTYPE_BYTES;
      default:     return PERF_BYTES;
    endcase
  endfunction

  function automatic perf_t perf_of(input logic [ENT_IDX_W-1:0] e);
    case (e)
      3'd1:    return '{PERF_RD_LAT, 64'd10000, 16'd15};
      3'd2:    return '{PERF_WR_LAT, 64'd10000, 16'd25};
      3'd3:    return '{PERF_RD_BW,  64'd1000,  16'd16};
      3'd4:    return '{PERF_WR_BW,  64'd1000,  16'd16};
      default: return '{PERF_NONE,   64'd0,     16'd0};
    endcase
  endfunction

  // response length in dwords: header plus entry rounded up
  function automatic logic [DW_IDX_W-1:0] rsp_dwords(input logic [ENT_IDX_W-1:0] e);
    logic [7:0] lb;
    lb = entry_bytes(e) + 8'd3;
    return DW_IDX_W'(HDR_DW) + DW_IDX_W'(lb >> 2);
  endfunction
endpackage

// File: rtl/cdat_req_check.sv
module cdat_req_check
  import cdat_resp_pkg::*;
#(
  parameter int unsigned LEN_W = 18
) (
  input  logic                 req_valid_i,
  input  logic [LEN_W-1:0]     req_len_i,
  input  logic [HANDLE_W-1:0]  req_handle_i,
  output logic                 accept_o,
  output logic [ENT_IDX_W-1:0] ent_o
);
  logic len_ok;
  logic handle_ok;

  assign len_ok    = req_len_i >= LEN_W'(REQ_DW);
  assign handle_ok = req_handle_i < HANDLE_W'(NUM_ENTRIES);
  assign accept_o  = req_valid_i && len_ok && handle_ok;
  assign ent_o     = req_handle_i[ENT_IDX_W-1:0];
endmodule

// File: rtl/cdat_entry_rom.sv
module cdat_entry_rom
  import cdat_resp_pkg::*;
#(
  parameter logic [63:0] REGION_SIZE   = 64'h0000_0002_4000_0000,
  parameter logic [7:0]  REGION_HANDLE = 8'h00
) (
  input  logic [ENT_IDX_W-1:0] ent_i,
  input  logic [DW_IDX_W-1:0]  dw_i,
  output logic [31:0]          data_o
);
  localparam int unsigned BYTE_IDX_W = DW_IDX_W + 2;

  function automatic logic [7:0] entry_byte(input logic [ENT_IDX_W-1:0] e,
                                            input logic [BYTE_IDX_W-1:0] b);
    logic [7:0]  len;
    logic [63:0] rsz;
    perf_t       p;
    sub_type_e   k;
    logic [7:0]  r;
    len = entry_bytes(e);
    rsz = REGION_SIZE;
    p   = perf_of(e);
    k   = entry_kind(e);
    r   = 8'h00;
    if (8'(b) < len) begin
      if (b == 0)      r = 8'(k);
      else if (b == 2) r = len;
      else if (b == 4) r = REGION_HANDLE;
      else if (b == 5) r = (k == SUB_REGION) ? NV_FLAG : (k == SUB_MEMTYPE) ? MEM_ATTR : 8'h00;
      else if (b == 6) r = (k == SUB_PERF) ? 8'(p.kind) : 8'h00;
      else if (b >= 8 && b < 16)
        r = (k == SUB_PERF) ? p.unit[8*b[2:0] +: 8] : 8'h00;
      else if (b >= 16 && b < 24)
        r = (k == SUB_PERF) ? p.value[8*b[0] +: 8] : rsz[8*b[2:0] +: 8];
    end
    return r;
  endfunction

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign data_o[8*l +: 8] = entry_byte(ent_i, {dw_i, 2'(l)});
  end
endmodule

// File: rtl/cdat_rsp_stream.sv
module cdat_rsp_stream
  import cdat_resp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [DW_IDX_W-1:0] total_i,
  input  logic                pop_i,
  output logic                ready_o,
  output logic [DW_IDX_W-1:0] idx_o
);
  logic [DW_IDX_W-1:0] idx_q;
  logic [DW_IDX_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      idx_q    <= '0;
      remain_q <= total_i;
    end else if (pop_i && remain_q != '0) begin
      idx_q    <= idx_q + 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  assign ready_o = remain_q != '0;
  assign idx_o   = idx_q;

  AST_POP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && ready_o && !load_i) |=> (idx_o == $past(idx_o) + 1'b1))
    else $error("pop did not advance");  // R9
  AST_LAST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && remain_q == 1 && !load_i) |=> !ready_o)
    else $error("ready held after last pop");  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !load_i) |=> !ready_o)
    else $error("ready rose without request");  // R9
  AST_LOAD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && total_i != '0) |=> (ready_o && idx_o == '0))
    else $error("load did not restart stream");  // R10
endmodule

// File: rtl/cdat_responder.sv
module cdat_responder
  import cdat_resp_pkg::*;
#(
  parameter int unsigned LEN_W         = 18,
  parameter logic [15:0] VENDOR_ID     = 16'h1E98,
  parameter logic [7:0]  OBJ_TYPE      = 8'h02,
  parameter logic [63:0] REGION_SIZE   = 64'h0000_0002_4000_0000,
  parameter logic [7:0]  REGION_HANDLE = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [15:0]      req_handle_i,
  input  logic             rd_en_i,
  output logic             ready_o,
  output logic [31:0]      rd_data_o
);
  localparam logic [HANDLE_W-1:0] END_HANDLE = '1;
  localparam logic [ENT_IDX_W-1:0] LAST_ENT  = ENT_IDX_W'(NUM_ENTRIES - 1);

  logic                 accept;
  logic [ENT_IDX_W-1:0] req_ent;
  logic [ENT_IDX_W-1:0] ent_q;
  logic [DW_IDX_W-1:0]  idx;
  logic [DW_IDX_W-1:0]  pl_idx;
  logic [31:0]          rom_data;
  logic [HANDLE_W-1:0]  next_handle;
  logic [DW_IDX_W-1:0]  cur_len;

  cdat_req_check #(.LEN_W(LEN_W)) u_check (
    .req_valid_i (req_valid_i),
    .req_len_i   (req_len_i),
    .req_handle_i(req_handle_i),
    .accept_o    (accept),
    .ent_o       (req_ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ent_q <= '0;
    else if (accept) ent_q <= req_ent;
  end

  cdat_rsp_stream u_stream (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .total_i(rsp_dwords(req_ent)),
    .pop_i  (rd_en_i),
    .ready_o(ready_o),
    .idx_o  (idx)
  );

  assign pl_idx = idx - DW_IDX_W'(HDR_DW);

  cdat_entry_rom #(
    .REGION_SIZE  (REGION_SIZE),
    .REGION_HANDLE(REGION_HANDLE)
  ) u_rom (
    .ent_i (ent_q),
    .dw_i  (pl_idx),
    .data_o(rom_data)
  );

  assign next_handle = (ent_q == LAST_ENT) ? END_HANDLE : HANDLE_W'(ent_q) + 1'b1;
  assign cur_len     = rsp_dwords(ent_q);

  always_comb begin
    case (idx)
      DW_IDX_W'(0): rd_data_o = {8'h00, OBJ_TYPE, VENDOR_ID};
      DW_IDX_W'(1): rd_data_o = 32'(cur_len);
      DW_IDX_W'(2): rd_data_o = {next_handle, 8'h00, 8'h00};
      default:      rd_data_o = rom_data;
    endcase
  end

  AST_SHORT_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_len_i < LEN_W'(REQ_DW) && !ready_o) |=> !ready_o)
    else $error("short request produced a response");  // R2
  AST_RANGE_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_handle_i >= 16'(NUM_ENTRIES) && !ready_o) |=> !ready_o)
    else $error("bad handle produced a response");  // R11
  AST_FIRST_IS_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (rd_data_o == {8'h00, OBJ_TYPE, VENDOR_ID}))
    else $error("response did not open with header");  // R3
endmodule

// File: tb/cdat_responder_test.sv
module cdat_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [17:0] req_len = '0;
  logic [15:0] req_handle = '0;
  logic        rd_en = 1'b0;
  logic        ready;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cdat_responder uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_len_i(req_len),
    .req_handle_i(req_handle), .rd_en_i(rd_en), .ready_o(ready), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_bytes(input int e);
    return (e == 0 || e == 5) ? 24 : 18;
  endfunction

  function automatic logic [31:0] exp_payload(input int e, input int d);
    logic [7:0]  dt;
    logic [31:0] unit;
    logic [31:0] val;
    if (e == 0 || e == 5) begin
      case (d)
        0: return (e == 0) ? 32'h0018_0000 : 32'h0018_0002;
        1: return (e == 0) ? 32'h0000_0400 : 32'h0000_0200;
        4: return 32'h4000_0000;
        5: return 32'h0000_0002;
        default: return 32'h0;
      endcase
    end
    dt   = (e == 1) ? 8'd1 : (e == 2) ? 8'd2 : (e == 3) ? 8'd4 : 8'd5;
    unit = (e <= 2) ? 32'd10000 : 32'd1000;
    val  = (e == 1) ? 32'd15 : (e == 2) ? 32'd25 : 32'd16;
    case (d)
      0: return 32'h0012_0001;
      1: return {8'h00, dt, 16'h0000};
      2: return unit;
      4: return val;
      default: return 32'h0;
    endcase
  endfunction

  // driver: issue request, push expected response when it should be accepted
  task automatic send(input int len, input int h);
    int pdw;
    @(negedge clk);
    req_valid  = 1'b1;
    req_len    = 18'(len);
    req_handle = 16'(h);
    @(negedge clk);
    req_valid  = 1'b0;
    if (len >= 3 && h >= 0 && h < 6) begin
      exp_q.delete();
      tag_q.delete();
      pdw = (exp_bytes(h) + 3) / 4;
      exp_q.push_back(32'h0002_1E98);       tag_q.push_back("R3 header");
      exp_q.push_back(32'(3 + pdw));        tag_q.push_back("R4 length");
      exp_q.push_back({(h == 5) ? 16'hFFFF : 16'(h + 1), 16'h0000});
      tag_q.push_back("R5 next handle");
      for (int d = 0; d < pdw; d++) begin
        exp_q.push_back(exp_payload(h, d));
        tag_q.push_back(d == 0 ? "R7 subheader" : d == 4 ? "R8 R6 value/pad" : "R6 R8 payload");
      end
    end
  endtask

  // monitor: pop and compare up to n items
  task automatic drain(input int n);
    for (int i = 0; i < n && exp_q.size() > 0; i++) begin
      check("R9 ready while pending", 32'(ready), 32'd1);
      check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    if (exp_q.size() == 0) check("R9 ready clears after last", 32'(ready), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", 32'(ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", 32'(ready), 32'd0);

    // full walk of the table, mixed request lengths
    for (int h = 0; h < 6; h++) begin
      send((h % 2 == 0) ? 3 : 40, h);
      drain(99);
    end

    // pops while idle have no effect
    rd_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R9 idle pop keeps ready low", 32'(ready), 32'd0);
    end
    rd_en = 1'b0;
    send(4, 2);
    drain(99);

    // short requests while idle
    send(2, 0);
    check("R2 short request idle", 32'(ready), 32'd0);
    send(0, 1);
    check("R2 zero length idle", 32'(ready), 32'd0);

    // short request while pending: response continues
    send(3, 1);
    drain(4);
    send(1, 3);
    drain(99);

    // replace mid-stream
    send(3, 0);
    drain(3);
    send(3, 5);
    drain(99);

    // out of range handle, idle and pending
    send(3, 6);
    check("R11 bad handle idle", 32'(ready), 32'd0);
    send(3, 4);
    drain(2);
    send(5, 9);
    drain(99);
    send(3, 16'hFFFF);
    check("R11 end marker handle dropped", 32'(ready), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule